// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block gathers interrupt events for a small 8-bit-class processor core and decides when the core must jump to its interrupt handler. It has three groups of sources:

- **Core group.** An external pin, a port-change pulse and a timer-overflow pulse.
- **Group A.** A peripheral group of `PA_W` sources.
- **Group B.** A peripheral group of `PB_W` sources.

Each source owns a sticky flag and an enable bit. A peripheral-enable bit gates both peripheral groups. A global enable gates every group.

Software sees six register words through a simple read/write port. The core supplies an instruction-boundary strobe and a return-from-interrupt command. The block answers with a one-cycle vector request and a fixed handler address. The core's pipeline pushes the return address, not this block.

Hardware never clears a flag. The handler must clear the flag it served before it returns. Otherwise the same request fires again right after the return.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A source event sets its flag on the next clock edge, whatever the state of its enable, the peripheral enable or the global enable. Taking a vector leaves every flag unchanged.
- R2: A vector is taken only when the global enable is 1 and some flag is set together with its enable. A group A or group B flag counts only while the peripheral enable is also 1.
- R3: After reset, every register word reads 0 and `vec_req` is 0.
- R4: Taking a vector has three effects:
  - `vec_req` is high for exactly one cycle.
  - The global enable drops to 0 on the same clock edge.
  - `vec_addr` always reads 0x0004.
- R5: `ret_from_irq` sets the global enable on the next edge. If an enabled flag is still set, a new vector follows one edge later.
- R6: A register write that clears the global enable blocks a vector that would otherwise be taken in that same cycle. The flag stays set, and the vector is taken after the global enable returns.
- R7: A vector is taken only in a cycle where `instr_boundary` is 1. Until then a pending request waits.
- R8: Software writes to flag fields work bit by bit:
  - Writing 1 sets a flag bit, and writing 0 clears it.
  - If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
  - The register words are at these addresses:
    - 0: core word.
    - 1: group A flags.
    - 2: group A enables.
    - 3: group B flags.
    - 4: group B enables.
    - 5: config word.
  - The core word bits are:
    - bit 0: pin flag.
    - bit 1: port-change flag.
    - bit 2: timer flag.
    - bit 3: pin enable.
    - bit 4: port-change enable.
    - bit 5: timer enable.
    - bit 6: peripheral enable.
    - bit 7: global enable.
  - In the config word, bit 0 set to 1 selects the rising pin edge and 0 selects the falling edge.
- R9: The external pin passes through two synchronizer flops. Only the selected edge sets the pin flag, three edges after the pin changes. With enables set and the strobe high, the vector follows four edges after the change.
- R10: A one-cycle source pulse sets its flag one edge later. With enables set and the strobe high, `vec_req` goes high two edges after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | External interrupt pin, asynchronous |
| port_chg_pulse | input | 1 | Port-change event, one-cycle pulse |
| tmr_ovf_pulse | input | 1 | Timer-overflow event, one-cycle pulse |
| grp_a_pulse | input | PA_W | Group A event pulses |
| grp_b_pulse | input | PB_W | Group B event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| instr_boundary | input | 1 | High in cycles where the core may accept a vector |
| ret_from_irq | input | 1 | Return-from-interrupt command |
| vec_req | output | 1 | One-cycle vector request |
| vec_addr | output | PC_W | Handler address, fixed at 0x0004 |

## Verification
The expected times of results, counted in clock edges after a stimulus driven on a falling edge, are:

- **Source pulse.** The flag is visible after one edge. `vec_req` rises after two edges.
- **Pin edge.** The flag is visible after three edges and `vec_req` rises after four.
- **Register write or `ret_from_irq`.** The new enables apply after one edge. Any vector they release appears after two edges.
- **Strobe rising on an already pending request.** `vec_req` appears after one edge.

The driver computes the exact cycle number at which each vector is due and queues it. A monitor samples `vec_req` on every falling edge and flags three cases: a missing vector, a late vector, or any vector not in the queue. Register readbacks are sampled one time step after the address settles, at the cycle the flag is due.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt aggregation controller.
// Assumes 8-bit register words and at most 8 sources per peripheral group.
package irq_agg_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int CORE_N = 3;

    // Register word addresses
    typedef enum logic [ADDR_W-1:0] {
        ADR_CORE   = 3'd0,
        ADR_GA_FLG = 3'd1,
        ADR_GA_EN  = 3'd2,
        ADR_GB_FLG = 3'd3,
        ADR_GB_EN  = 3'd4,
        ADR_CFG    = 3'd5
    } reg_adr_e;

    // Core word layout: flags [2:0], enables [5:3], then peripheral and global enables
    localparam int CW_FLG_LO = 0;
    localparam int CW_EN_LO  = 3;
    localparam int CW_PEIE   = 6;
    localparam int CW_GIE    = 7;

    // Index of each core source inside its flag and enable fields
    localparam int SRC_PIN   = 0;
    localparam int SRC_PORT  = 1;
    localparam int SRC_TMR   = 2;

    // Config word: bit 0 = 1 selects the rising pin edge
    localparam int CFG_RISE  = 0;
endpackage

// File: rtl/irq_pin_edge.sv
// Synchronizes the asynchronous interrupt pin and reports the selected edge.
// Assumes the pin is low while reset is asserted, so no false edge appears
// after reset. Output is a one-cycle pulse, SYNC_N cycles after the pin moves.
module irq_pin_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic rise_sel,
    output logic edge_hit
);
    // sh[SYNC_N-1] is the synchronized level; sh[SYNC_N] is its previous value
    logic [SYNC_N:0] sh;

    // Purpose: shift the pin through the synchronizer and the history flop
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_N-1:0], pin_async};
    end

    logic rise_w, fall_w;

    // Purpose: detect both edges and pick the configured one
    always_comb begin
        rise_w   = sh[SYNC_N-1] & ~sh[SYNC_N];
        fall_w   = ~sh[SYNC_N-1] & sh[SYNC_N];
        edge_hit = rise_sel ? rise_w : fall_w;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// One group of W interrupt sources, each with a sticky flag and an enable bit.
// Software writes set or clear flags bit by bit. A hardware set in the same
// cycle overrides a software clear. any_req reports any enabled, set flag.
module irq_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic         flag_we,
    input  logic [W-1:0] flag_wdata,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] flags,
    output logic [W-1:0] enables,
    output logic         any_req
);
    logic [W-1:0] flag_nxt;
    logic [W-1:0] en_nxt;

    for (genvar i = 0; i < W; i++) begin : g_src
        // Purpose: per-source next state, hardware set first
        always_comb begin
            if (hw_set[i])    flag_nxt[i] = 1'b1;
            else if (flag_we) flag_nxt[i] = flag_wdata[i];
            else              flag_nxt[i] = flags[i];
            en_nxt[i] = en_we ? en_wdata[i] : enables[i];
        end
    end

    // Purpose: hold flag and enable state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags   <= flag_nxt;
            enables <= en_nxt;
        end
    end

    // Purpose: reduce the enabled flags to one request
    always_comb any_req = |(flags & enables);
endmodule

// File: rtl/irq_vector_gate.sv
// Holds the global and peripheral enables and decides when to vector.
// A vector is taken on an instruction boundary when the global enable is set
// and a request is pending. A same-cycle write that clears the global enable
// blocks it. The request stays pending because flags are never touched here.
module irq_vector_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic periph_req,
    input  logic instr_boundary,
    input  logic ret_from_irq,
    input  logic core_we,
    input  logic wr_gie,
    input  logic wr_peie,
    output logic gie,
    output logic peie,
    output logic vec_req
);
    logic pending, gie_drop_wr, take;

    // Purpose: combine the groups and form the take condition
    always_comb begin
        pending     = core_req | (peie & periph_req);
        gie_drop_wr = core_we & ~wr_gie;
        take        = instr_boundary & gie & pending & ~gie_drop_wr;
    end

    // Purpose: update the enables; a take clears first, then return, then the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie     <= 1'b0;
            peie    <= 1'b0;
            vec_req <= 1'b0;
        end else begin
            if (take)              gie <= 1'b0;
            else if (ret_from_irq) gie <= 1'b1;
            else if (core_we)      gie <= wr_gie;
            if (core_we)           peie <= wr_peie;
            vec_req <= take;
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the interrupt aggregation controller: core group, two peripheral
// groups, register port, pin edge logic and vector gate.
// Assumes the core accepts a vector only while instr_boundary is high.
module irq_vector_ctrl #(
    parameter int          PA_W       = 8,
    parameter int          PB_W       = 6,
    parameter int          PC_W       = 13,
    parameter logic [12:0] VEC_TARGET = 13'h0004
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             pin_async,
    input  logic                             port_chg_pulse,
    input  logic                             tmr_ovf_pulse,
    input  logic [PA_W-1:0]                  grp_a_pulse,
    input  logic [PB_W-1:0]                  grp_b_pulse,
    input  logic                             reg_we,
    input  logic [irq_agg_pkg::ADDR_W-1:0]   reg_addr,
    input  logic [irq_agg_pkg::REG_W-1:0]    reg_wdata,
    output logic [irq_agg_pkg::REG_W-1:0]    reg_rdata,
    input  logic                             instr_boundary,
    input  logic                             ret_from_irq,
    output logic                             vec_req,
    output logic [PC_W-1:0]                  vec_addr
);
    import irq_agg_pkg::*;

    localparam int CN = CORE_N;

    // Write decode
    logic we_core, we_ga_f, we_ga_e, we_gb_f, we_gb_e, we_cfg;

    // Purpose: one write strobe per register word
    always_comb begin
        we_core = reg_we && (reg_addr == ADR_CORE);
        we_ga_f = reg_we && (reg_addr == ADR_GA_FLG);
        we_ga_e = reg_we && (reg_addr == ADR_GA_EN);
        we_gb_f = reg_we && (reg_addr == ADR_GB_FLG);
        we_gb_e = reg_we && (reg_addr == ADR_GB_EN);
        we_cfg  = reg_we && (reg_addr == ADR_CFG);
    end

    logic cfg_rise;

    // Purpose: pin edge select register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_rise <= 1'b0;
        else if (we_cfg) cfg_rise <= reg_wdata[CFG_RISE];
    end

    logic pin_hit;
    irq_pin_edge #(.SYNC_N(2)) pin_i (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .rise_sel(cfg_rise), .edge_hit(pin_hit)
    );

    logic [CN-1:0] core_set;

    // Purpose: gather the core group events
    always_comb begin
        core_set           = '0;
        core_set[SRC_PIN]  = pin_hit;
        core_set[SRC_PORT] = port_chg_pulse;
        core_set[SRC_TMR]  = tmr_ovf_pulse;
    end

    logic [CN-1:0]   core_flg, core_en;
    logic [PA_W-1:0] ga_flg, ga_en;
    logic [PB_W-1:0] gb_flg, gb_en;
    logic            core_any, ga_any, gb_any;

    irq_flag_bank #(.W(CN)) core_bank_i (
        .clk(clk), .rst_n(rst_n), .hw_set(core_set),
        .flag_we(we_core), .flag_wdata(reg_wdata[CW_FLG_LO +: CN]),
        .en_we(we_core),   .en_wdata(reg_wdata[CW_EN_LO +: CN]),
        .flags(core_flg), .enables(core_en), .any_req(core_any)
    );

    irq_flag_bank #(.W(PA_W)) grp_a_i (
        .clk(clk), .rst_n(rst_n), .hw_set(grp_a_pulse),
        .flag_we(we_ga_f), .flag_wdata(reg_wdata[PA_W-1:0]),
        .en_we(we_ga_e),   .en_wdata(reg_wdata[PA_W-1:0]),
        .flags(ga_flg), .enables(ga_en), .any_req(ga_any)
    );

    irq_flag_bank #(.W(PB_W)) grp_b_i (
        .clk(clk), .rst_n(rst_n), .hw_set(grp_b_pulse),
        .flag_we(we_gb_f), .flag_wdata(reg_wdata[PB_W-1:0]),
        .en_we(we_gb_e),   .en_wdata(reg_wdata[PB_W-1:0]),
        .flags(gb_flg), .enables(gb_en), .any_req(gb_any)
    );

    logic gie_w, peie_w;

    irq_vector_gate gate_i (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_any), .periph_req(ga_any | gb_any),
        .instr_boundary(instr_boundary), .ret_from_irq(ret_from_irq),
        .core_we(we_core), .wr_gie(reg_wdata[CW_GIE]), .wr_peie(reg_wdata[CW_PEIE]),
        .gie(gie_w), .peie(peie_w), .vec_req(vec_req)
    );

    // Purpose: fixed handler address
    always_comb vec_addr = PC_W'(VEC_TARGET);

    // Purpose: read mux; narrow groups read zero in their unused bits
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CORE: begin
                reg_rdata[CW_FLG_LO +: CN] = core_flg;
                reg_rdata[CW_EN_LO +: CN]  = core_en;
                reg_rdata[CW_PEIE]         = peie_w;
                reg_rdata[CW_GIE]          = gie_w;
            end
            ADR_GA_FLG: reg_rdata[PA_W-1:0] = ga_flg;
            ADR_GA_EN:  reg_rdata[PA_W-1:0] = ga_en;
            ADR_GB_FLG: reg_rdata[PB_W-1:0] = gb_flg;
            ADR_GB_EN:  reg_rdata[PB_W-1:0] = gb_en;
            ADR_CFG:    reg_rdata[CFG_RISE] = cfg_rise;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Assertion checker for irq_vector_ctrl, attached by bind below.
module irq_vector_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gie,
    input logic       vec_req,
    input logic       instr_boundary,
    input logic       ret_from_irq,
    input logic       tmr_pulse,
    input logic [2:0] core_flags
);
    // R4
    vec_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |=> !vec_req);

    // R4
    vec_drops_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !gie);

    // R7
    vec_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(instr_boundary));

    // R2
    vec_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> $past(gie));

    // R1
    flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tmr_pulse) |-> core_flags[2]);

    // R5
    ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ret_from_irq) && !vec_req) |-> gie);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .gie(gie_w), .vec_req(vec_req),
    .instr_boundary(instr_boundary), .ret_from_irq(ret_from_irq),
    .tmr_pulse(tmr_ovf_pulse), .core_flags(core_flg)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
    localparam int PA_W = 8;
    localparam int PB_W = 6;
    localparam int PC_W = 13;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            pin_async = 1'b0, port_chg_pulse = 1'b0, tmr_ovf_pulse = 1'b0;
    logic [PA_W-1:0] grp_a_pulse = '0;
    logic [PB_W-1:0] grp_b_pulse = '0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            instr_boundary = 1'b1, ret_from_irq = 1'b0;
    logic            vec_req;
    logic [PC_W-1:0] vec_addr;

    irq_vector_ctrl #(.PA_W(PA_W), .PB_W(PB_W), .PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .port_chg_pulse(port_chg_pulse), .tmr_ovf_pulse(tmr_ovf_pulse),
        .grp_a_pulse(grp_a_pulse), .grp_b_pulse(grp_b_pulse),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .instr_boundary(instr_boundary),
        .ret_from_irq(ret_from_irq), .vec_req(vec_req), .vec_addr(vec_addr)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Scoreboard monitor: compare vec_req against the queued due cycles
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                check("R4 vector missing at due cycle", 0, exp_q[0]);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                check("R4 vec_req at due cycle", {31'd0, vec_req}, 1);
                void'(exp_q.pop_front());
            end else if (vec_req) begin
                check("R2 unexpected vec_req", cyc, 0);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d, output int at);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; at = cyc;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic pulse_tmr(output int at);
        @(negedge clk);
        tmr_ovf_pulse = 1'b1; at = cyc;
        @(negedge clk);
        tmr_ovf_pulse = 1'b0;
    endtask

    task automatic ret_cmd(output int at);
        @(negedge clk);
        ret_from_irq = 1'b1; at = cyc;
        @(negedge clk);
        ret_from_irq = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state
        for (int a = 0; a < 6; a++) rd(a[2:0], 8'h00, "R3 reset word");
        check("R3 vec_req after reset", {31'd0, vec_req}, 0);
        check("R4 vec_addr fixed", {19'd0, vec_addr}, 32'h4);

        // R10 + R1: flag one edge after pulse, with everything masked
        @(negedge clk);
        tmr_ovf_pulse = 1'b1; port_chg_pulse = 1'b1; reg_addr = 3'd0;
        @(negedge clk);
        tmr_ovf_pulse = 1'b0; port_chg_pulse = 1'b0;
        #1 check("R10 flag one edge after pulse", reg_rdata, 8'h06);
        idle(4);
        rd(3'd0, 8'h06, "R1 masked flags stay set");

        // R8 software clear and set
        wr(3'd0, 8'h00, t);
        rd(3'd0, 8'h00, "R8 write 0 clears flags");
        wr(3'd0, 8'h07, t);
        rd(3'd0, 8'h07, "R8 write 1 sets flags");
        wr(3'd0, 8'h00, t);

        // R8 hardware set beats software clear in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00; tmr_ovf_pulse = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tmr_ovf_pulse = 1'b0;
        rd(3'd0, 8'h04, "R8 hw set wins over sw clear");
        wr(3'd0, 8'h00, t);

        // R10 + R4: timer vector two edges after pulse, gie dropped, flag kept
        wr(3'd0, 8'hA0, t);
        pulse_tmr(t);
        exp_q.push_back(t + 2);
        idle(3);
        rd(3'd0, 8'h24, "R4 gie cleared, R1 flag kept after vector");

        // R5 return re-enables and the uncleared flag fires again
        ret_cmd(t);
        exp_q.push_back(t + 2);
        idle(3);
        wr(3'd0, 8'h20, t);
        rd(3'd0, 8'h20, "R5 flag cleared before re-enable");
        ret_cmd(t);
        idle(3);
        rd(3'd0, 8'hA0, "R5 gie set by return, no refire");

        // R7 boundary strobe low defers the vector
        @(negedge clk);
        instr_boundary = 1'b0;
        pulse_tmr(t);
        idle(4);
        @(negedge clk);
        instr_boundary = 1'b1; t = cyc;
        exp_q.push_back(t + 1);
        idle(3);

        // R6 gie-clearing write blocks a same-cycle vector; flag kept
        @(negedge clk);
        instr_boundary = 1'b0;
        ret_cmd(t);
        idle(1);
        @(negedge clk);
        instr_boundary = 1'b1; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h24;
        @(negedge clk);
        reg_we = 1'b0;
        idle(2);
        rd(3'd0, 8'h24, "R6 request blocked but still pending");
        ret_cmd(t);
        exp_q.push_back(t + 2);
        idle(3);
        wr(3'd0, 8'h00, t);

        // R2 peripheral group needs the peripheral enable
        wr(3'd2, 8'h08, t);
        wr(3'd0, 8'h80, t);
        @(negedge clk);
        grp_a_pulse = 8'h08;
        @(negedge clk);
        grp_a_pulse = '0;
        idle(3);
        rd(3'd1, 8'h08, "R2 group A flag set without vector");
        wr(3'd0, 8'hC0, t);
        exp_q.push_back(t + 2);
        idle(3);
        rd(3'd0, 8'h40, "R4 gie dropped after group A vector");
        wr(3'd1, 8'h00, t);

        // R2 group B path
        wr(3'd4, 8'hFF, t);
        rd(3'd4, 8'h3F, "R8 group B enables limited to width");
        wr(3'd0, 8'hC0, t);
        @(negedge clk);
        grp_b_pulse = 6'h20; t = cyc;
        @(negedge clk);
        grp_b_pulse = '0;
        exp_q.push_back(t + 2);
        idle(3);
        wr(3'd3, 8'h00, t);
        wr(3'd0, 8'h00, t);

        // R9 rising-edge pin: flag after three edges, vector after four
        wr(3'd5, 8'h01, t);
        wr(3'd0, 8'h88, t);
        @(negedge clk);
        pin_async = 1'b1; t = cyc;
        exp_q.push_back(t + 4);
        @(negedge clk); @(negedge clk);
        reg_addr = 3'd0;
        #1 check("R9 pin flag not yet set at edge 2", reg_rdata, 8'h88);
        @(negedge clk);
        #1 check("R9 pin flag set at edge 3", reg_rdata, 8'h89);
        idle(3);
        rd(3'd0, 8'h09, "R9 pin vector taken");

        // R9 falling select: falling sets, rising ignored
        wr(3'd5, 8'h00, t);
        wr(3'd0, 8'h08, t);
        @(negedge clk);
        pin_async = 1'b0;
        idle(5);
        rd(3'd0, 8'h09, "R9 falling edge sets flag");
        wr(3'd0, 8'h08, t);
        @(negedge clk);
        pin_async = 1'b1;
        idle(5);
        rd(3'd0, 8'h08, "R9 rising edge ignored in falling mode");

        idle(4);
        check("R4 all queued vectors seen", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule